// File: doc/BRIEF.md
# Oversampled SPI Slave Transmitter

This block drives the serial data line of an SPI slave from inside the system-clock domain. The external SPI clock and the active-low select are not used as clocks: each passes through a synchronizer, and their edges are found by comparing consecutive synchronized samples. A rising SPI clock edge seen while the select is low moves the output to the next bit of the current 8-bit character. The master then samples that bit on its following rising edge. Because of the synchronizer and edge-detect registers, the output changes a fixed 3 to 4 system clocks after the external edge.

Bytes come in over a valid/ready interface. The block holds two bytes: the character being shifted and one pending character. When a character ends and no pending byte exists, an all-ones idle character goes out instead and a one-cycle underrun pulse is raised. A static input selects whether characters go out most-significant or least-significant bit first. A falling edge on the select restarts the current character from its first bit. While the bus is idle, the first bit of the next character is already on the line.

Top module: `spi_slave_tx`

## Requirements
- R1: After reset, spi_dout is 1 (the idle character is all ones), tx_ready is 1 and underrun is 0.
- R2: After a falling edge of spi_cs_n, and before the first rising spi_sck edge, spi_dout already carries the first bit of the current character.
- R3: While spi_cs_n is low, each rising spi_sck edge moves spi_dout to the next bit of the character. A master sampling spi_dout just before each rising edge therefore collects the character's bits in order.
- R4: spi_dout changes 3 to 4 system clocks after a rising spi_sck edge. The value is unchanged at the third clock and new at the fourth when the edge falls between clock edges.
- R5: While spi_cs_n is high, spi_sck edges have no effect: spi_dout stays constant and no bit or byte is consumed.
- R6: cfg_lsb_first = 0 sends bit 7 first; cfg_lsb_first = 1 sends bit 0 first.
- R7: After the 8th bit of a character, the pending byte becomes the next character with no gap in the bit stream.
- R8: If a character ends while no pending byte exists, the next character is 8'hFF and underrun pulses high for exactly one clock per such character.
- R9: tx_ready is high exactly when the pending slot is empty. A byte is taken on a clock edge where tx_valid and tx_ready are both high. While the select is high, a pending byte moves into an exhausted current character, so up to two bytes can be held ahead of a transfer.
- R10: A falling edge of spi_cs_n in the middle of a character restarts that same character from its first bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_lsb_first | input | 1 | Bit order: 0 = MSB first, 1 = LSB first (static during transfers) |
| spi_sck | input | 1 | SPI clock from the master, asynchronous |
| spi_cs_n | input | 1 | Active-low select from the master, asynchronous |
| tx_data | input | 8 | Byte offered for transmission |
| tx_valid | input | 1 | tx_data is valid |
| tx_ready | output | 1 | Pending slot is free; byte accepted when tx_valid is also high |
| spi_dout | output | 1 | Serial data to the master |
| underrun | output | 1 | One-clock pulse when an idle character replaces a missing byte |

## Verification
The bench measures the clock at which the output moves after an SPI clock edge. A design with one synchronizer stage too few or too many shows the new bit a clock early or holds the old bit a clock late. It toggles the SPI clock with the select high and checks that the held bytes still come out intact afterwards, which catches a design that shifts without looking at the select. It also aborts a character partway through and re-selects; a design that does not reset its bit position would send a rotated byte. Frames with fewer bytes loaded than the frame is long must yield all-ones characters and the matching number of underrun pulses, in both bit orders. A missing or doubled pulse, or stale data in place of the idle pattern, shows up as a mismatch.

// File: rtl/spi_tx_pkg.sv
package spi_tx_pkg;

    localparam int unsigned CHAR_W_DEF = 8;
    localparam int unsigned SYNC_DEPTH_DEF = 2;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_kind_e;

    typedef enum logic [1:0] {
        LOAD_NONE = 2'd0,
        LOAD_PEND = 2'd1,
        LOAD_IDLE = 2'd2
    } load_src_e;

endpackage

// File: rtl/spi_tx_sync.sv
module spi_tx_sync #(
    parameter int unsigned DEPTH   = spi_tx_pkg::SYNC_DEPTH_DEF,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level
);
    localparam int unsigned LAST = DEPTH - 1;

    typedef struct packed {
        logic [DEPTH-1:0] chain;
    } sync_state_t;

    sync_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.chain[0] = async_in;
        for (int i = 1; i < DEPTH; i++) begin
            s_d.chain[i] = s_q.chain[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.chain <= {DEPTH{RST_VAL}};
        end else begin
            s_q <= s_d;
        end
    end

    assign level = s_q.chain[LAST];

    initial begin
        assert (DEPTH >= 2) else $error("synchronizer needs at least two stages");
    end

endmodule

// File: rtl/spi_tx_edge.sv
module spi_tx_edge #(
    parameter spi_tx_pkg::edge_kind_e KIND    = spi_tx_pkg::EDGE_RISE,
    parameter logic                   RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic pulse
);
    typedef struct packed {
        logic prev;
        logic pulse;
    } edge_state_t;

    edge_state_t s_d, s_q;
    logic        hit;

    generate
        if (KIND == spi_tx_pkg::EDGE_RISE) begin : g_rise
            assign hit = level & ~s_q.prev;
        end else begin : g_fall
            assign hit = ~level & s_q.prev;
        end
    endgenerate

    always_comb begin
        s_d       = s_q;
        s_d.prev  = level;
        s_d.pulse = hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.prev  <= RST_VAL;
            s_q.pulse <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pulse = s_q.pulse;

    // One physical edge yields a single-cycle pulse (feeds the fixed latency of R4)
    assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.pulse |=> !s_q.pulse);

endmodule

// File: rtl/spi_tx_shifter.sv
module spi_tx_shifter #(
    parameter int unsigned CHAR_W = spi_tx_pkg::CHAR_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lsb_first,
    input  logic              sck_rise,
    input  logic              cs_high,
    input  logic              cs_fall,
    input  logic [CHAR_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              dout,
    output logic              underrun
);
    import spi_tx_pkg::*;

    localparam int unsigned CNT_W = (CHAR_W > 1) ? $clog2(CHAR_W) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CHAR_W - 1);

    typedef struct packed {
        logic [CHAR_W-1:0] cur;
        logic [CHAR_W-1:0] pend;
        logic              pend_full;
        logic              cur_spent;
        logic [CNT_W-1:0]  bitcnt;
        logic              dout;
        logic              underrun;
    } shift_state_t;

    shift_state_t s_d, s_q;
    load_src_e    load_src;
    logic         accept;
    logic [CNT_W-1:0] bit_idx;

    always_comb begin
        s_d          = s_q;
        s_d.underrun = 1'b0;
        load_src     = LOAD_NONE;
        accept       = in_valid && !s_q.pend_full;

        if (cs_fall) begin
            s_d.bitcnt = '0;
        end else if (sck_rise && !cs_high) begin
            if (s_q.bitcnt == CNT_LAST) begin
                s_d.bitcnt = '0;
                load_src   = s_q.pend_full ? LOAD_PEND : LOAD_IDLE;
            end else begin
                s_d.bitcnt = s_q.bitcnt + 1'b1;
            end
        end else if (cs_high && s_q.cur_spent && s_q.pend_full) begin
            s_d.bitcnt = '0;
            load_src   = LOAD_PEND;
        end

        case (load_src)
            LOAD_PEND: begin
                s_d.cur       = s_q.pend;
                s_d.pend_full = 1'b0;
                s_d.cur_spent = 1'b0;
            end
            LOAD_IDLE: begin
                s_d.cur       = '1;
                s_d.cur_spent = 1'b1;
                s_d.underrun  = 1'b1;
            end
            default: ;
        endcase

        if (accept) begin
            s_d.pend      = in_data;
            s_d.pend_full = 1'b1;
        end

        bit_idx  = lsb_first ? s_d.bitcnt : (CNT_LAST - s_d.bitcnt);
        s_d.dout = s_d.cur[bit_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cur       <= '1;
            s_q.pend      <= '0;
            s_q.pend_full <= 1'b0;
            s_q.cur_spent <= 1'b1;
            s_q.bitcnt    <= '0;
            s_q.dout      <= 1'b1;
            s_q.underrun  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign in_ready = !s_q.pend_full;
    assign dout     = s_q.dout;
    assign underrun = s_q.underrun;

    // R9: a taken byte occupies the pending slot in the next cycle
    assert_accept_fills_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R8: an idle character is only inserted when nothing was pending
    assert_underrun_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> !$past(s_q.pend_full));

    // R10: select falling edge restarts the character
    assert_cs_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> (s_q.bitcnt == '0));

    // R5: clock edges while deselected leave the line alone
    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_rise && cs_high && !cs_fall && !(s_q.cur_spent && s_q.pend_full))
        |=> $stable(dout));

    // R3: mid-character clock edges step the bit position by one
    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_rise && !cs_high && !cs_fall && s_q.bitcnt != CNT_LAST)
        |=> (s_q.bitcnt == CNT_W'($past(s_q.bitcnt) + 1'b1)));

endmodule

// File: rtl/spi_slave_tx.sv
module spi_slave_tx #(
    parameter int unsigned CHAR_W     = spi_tx_pkg::CHAR_W_DEF,
    parameter int unsigned SYNC_DEPTH = spi_tx_pkg::SYNC_DEPTH_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_lsb_first,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic [CHAR_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              spi_dout,
    output logic              underrun
);
    import spi_tx_pkg::*;

    logic sck_lvl, cs_lvl;
    logic sck_rise, cs_fall;

    spi_tx_sync #(.DEPTH(SYNC_DEPTH), .RST_VAL(1'b0)) u_sync_sck (
        .clk(clk), .rst_n(rst_n), .async_in(spi_sck), .level(sck_lvl));

    spi_tx_sync #(.DEPTH(SYNC_DEPTH), .RST_VAL(1'b1)) u_sync_cs (
        .clk(clk), .rst_n(rst_n), .async_in(spi_cs_n), .level(cs_lvl));

    spi_tx_edge #(.KIND(EDGE_RISE), .RST_VAL(1'b0)) u_edge_sck (
        .clk(clk), .rst_n(rst_n), .level(sck_lvl), .pulse(sck_rise));

    spi_tx_edge #(.KIND(EDGE_FALL), .RST_VAL(1'b1)) u_edge_cs (
        .clk(clk), .rst_n(rst_n), .level(cs_lvl), .pulse(cs_fall));

    spi_tx_shifter #(.CHAR_W(CHAR_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .lsb_first(cfg_lsb_first),
        .sck_rise (sck_rise),
        .cs_high  (cs_lvl),
        .cs_fall  (cs_fall),
        .in_data  (tx_data),
        .in_valid (tx_valid),
        .in_ready (tx_ready),
        .dout     (spi_dout),
        .underrun (underrun)
    );

endmodule

// File: tb/tb_spi_slave_tx.sv
module tb_spi_slave_tx;

    localparam int HALF = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_lsb_first = 1'b0;
    logic       spi_sck = 1'b0;
    logic       spi_cs_n = 1'b1;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0;
    logic       tx_ready, spi_dout, underrun;

    int compared = 0;
    int mismatched = 0;
    int ucnt = 0;
    bit done = 1'b0;
    logic [7:0] got [4];

    always #2.5 clk = ~clk;

    spi_slave_tx dut (
        .clk(clk), .rst_n(rst_n), .cfg_lsb_first(cfg_lsb_first),
        .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .spi_dout(spi_dout),
        .underrun(underrun));

    always @(posedge clk) if (rst_n && underrun) ucnt <= ucnt + 1;

    function automatic logic exp_bit(logic [7:0] b, int pos, logic lsb);
        return lsb ? b[pos] : b[7-pos];
    endfunction

    function automatic logic [7:0] add_bit(logic [7:0] acc, logic bit_in, logic lsb);
        return lsb ? {bit_in, acc[7:1]} : {acc[6:0], bit_in};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        tx_data  = b;
        tx_valid = 1'b1;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rise_fall(input bit lat, input logic old_b, input logic new_b);
        spi_sck = 1'b1;
        if (lat) begin
            wait_clk(3);
            chk(spi_dout == old_b, "R4 held at 3 clocks", spi_dout, old_b);
            wait_clk(1);
            chk(spi_dout == new_b, "R4 new at 4 clocks", spi_dout, new_b);
            wait_clk(HALF - 4);
        end else begin
            wait_clk(HALF);
        end
        spi_sck = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic run_frame(input int n, input bit lat, input logic [7:0] first_b);
        @(negedge clk);
        spi_cs_n = 1'b0;
        wait_clk(6);
        for (int i = 0; i < n; i++) begin
            logic [7:0] acc = 8'h00;
            for (int j = 0; j < 8; j++) begin
                logic b = spi_dout;
                acc = add_bit(acc, b, cfg_lsb_first);
                rise_fall(lat && i == 0 && j == 0, exp_bit(first_b, 0, cfg_lsb_first),
                          exp_bit(first_b, 1, cfg_lsb_first));
            end
            got[i] = acc;
        end
        wait_clk(4);
        spi_cs_n = 1'b1;
        wait_clk(8);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        int u0;
        void'($urandom(32'd20240611));
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(2);

        // R1: reset state
        chk(spi_dout == 1'b1, "R1 dout", spi_dout, 1);
        chk(tx_ready == 1'b1, "R1 ready", tx_ready, 1);
        chk(underrun == 1'b0, "R1 underrun", underrun, 0);

        // R9 / R2: two bytes held while idle, first bit shown before clocking
        push(8'h55);
        push(8'hC3);
        wait_clk(3);
        chk(tx_ready == 1'b0, "R9 slot full", tx_ready, 0);
        chk(spi_dout == exp_bit(8'h55, 0, 1'b0), "R2 first bit idle", spi_dout, 0);

        // R5: clock edges while deselected change nothing
        u0 = ucnt;
        for (int k = 0; k < 5; k++) begin
            spi_sck = 1'b1;
            wait_clk(HALF);
            chk(spi_dout == 1'b0, "R5 hold high", spi_dout, 0);
            spi_sck = 1'b0;
            wait_clk(HALF);
            chk(spi_dout == 1'b0, "R5 hold low", spi_dout, 0);
        end
        chk(ucnt == u0, "R5 no underrun", ucnt, u0);

        // R3/R4/R7/R8: two held bytes then idle character, MSB first
        u0 = ucnt;
        run_frame(3, 1'b1, 8'h55);
        chk(got[0] == 8'h55, "R3 byte0 msb", got[0], 8'h55);
        chk(got[1] == 8'hC3, "R7 byte1 back-to-back", got[1], 8'hC3);
        chk(got[2] == 8'hFF, "R8 idle char", got[2], 8'hFF);
        chk(ucnt - u0 == 2, "R8 pulse count", ucnt - u0, 2);

        // R6: LSB first
        cfg_lsb_first = 1'b1;
        push(8'h1E);
        wait_clk(3);
        chk(spi_dout == 1'b0, "R6 lsb first bit", spi_dout, 0);
        run_frame(1, 1'b0, 8'h1E);
        chk(got[0] == 8'h1E, "R6 lsb byte", got[0], 8'h1E);

        // R10: abort mid-character, restart from first bit
        push(8'hA7);
        wait_clk(3);
        @(negedge clk);
        spi_cs_n = 1'b0;
        wait_clk(6);
        for (int j = 0; j < 3; j++) rise_fall(1'b0, 1'b0, 1'b0);
        spi_cs_n = 1'b1;
        wait_clk(8);
        chk(spi_dout == exp_bit(8'hA7, 3, 1'b1), "R5 hold after abort", spi_dout,
            exp_bit(8'hA7, 3, 1'b1));
        run_frame(1, 1'b0, 8'hA7);
        chk(got[0] == 8'hA7, "R10 restart byte", got[0], 8'hA7);

        // Random frames: R3 R6 R7 R8 R9
        for (int f = 0; f < 40; f++) begin
            int n = 1 + int'($urandom % 3);
            int maxp = (n < 2) ? n : 2;
            int p = int'($urandom % (maxp + 1));
            logic [7:0] exp_b [4];
            int uexp;
            cfg_lsb_first = logic'($urandom % 2);
            for (int i = 0; i < 4; i++) exp_b[i] = 8'hFF;
            for (int i = 0; i < p; i++) begin
                exp_b[i] = 8'($urandom);
                push(exp_b[i]);
            end
            wait_clk(4);
            u0 = ucnt;
            run_frame(n, 1'b0, exp_b[0]);
            for (int i = 0; i < n; i++)
                chk(got[i] == exp_b[i], "R3 R7 random byte", got[i], exp_b[i]);
            uexp = n - ((p > 0) ? p - 1 : 0);
            chk(ucnt - u0 == uexp, "R8 random underruns", ucnt - u0, uexp);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule